// File: doc/BRIEF.md
# Dual-Mode Programmable Timer Pair

This peripheral holds a 64-bit up-counter that can run as one wide timer or as two separate 32-bit timers, a low half and a high half. Software drives it over a simple word-wide register port: one address, one write strobe and write data. Read data is combinational from the address. Each half has a counter register, a period register and a 2-bit enable-mode field. The enable fields share one control word. A global control word picks the timer mode and holds a release bit for each half.

When a running counter equals its period, it returns to zero on the next clock and the matching interrupt output goes high for that one clock. In one-shot mode the half then disables itself. In continuous mode it keeps running. A period of all ones therefore gives a free-running counter that interrupts on every wrap. The register port carries plain control traffic and has no valid/ready handshake, because every access completes in the cycle it is presented.

Top module: `timer_pair`

## Requirements
- R1: Offset 0x00 reads the constant 0x7A1E0001 (parameter default), and a write to it leaves the value read back unchanged.
- R2: After reset, every counter, period, control and global-control register reads zero, and both interrupt outputs are low.
- R3: Byte offsets decode as follows, and any other offset reads zero with writes ignored:
  - 0x10: low counter
  - 0x14: high counter
  - 0x18: low period
  - 0x1C: high period
  - 0x20: timer control
  - 0x24: global control
- R4: Global-control bit 0 releases the low half and bit 1 releases the high half, where 1 means released. A held half reads zero, does not count and ignores writes to its counter. In 64-bit mode, a hold on either bit clears and holds both halves.
- R5: A running half whose counter equals its period reads zero one clock later, and its interrupt output is high for exactly that clock. A counter write in the same cycle takes priority and suppresses the interrupt.
- R6: In one-shot mode, reaching the period raises one interrupt, clears that half's enable field to 0 and leaves the counter at zero.
- R7: Enable code 0 freezes the counter at its present value without clearing it.
- R8: The low half's enable field is timer-control bits [7:6] and the high half's is bits [23:22].
  - Codes: 1 is one-shot, 2 is continuous, and 3 also runs continuously.
  - All other control bits read zero.
- R9: Global-control bits [3:2] select the mode: 0 is 64-bit, 1 is dual 32-bit, and 2 or 3 halt both counters with no interrupts. Global-control bits above 3 read zero.
- R10: In 64-bit mode the low enable field governs the whole counter. The high half counts a carry when the low half passes all ones. The match compares all 64 bits and is reported on the low interrupt, and the high interrupt stays low.
- R11: In continuous mode a counter written directly keeps incrementing from the written value. With a period of all ones it wraps from all ones to zero and raises an interrupt on each wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge is one count tick |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_lo | output | 1 | One-clock pulse when the low half (or the 64-bit counter) wraps |
| irq_hi | output | 1 | One-clock pulse when the high half wraps in dual mode |

## Verification
The hardest case to reach is the carry from the low word into the high word in 64-bit mode, together with a wrap of the free-running counter at all ones. Counting there from zero would take billions of clocks. The stimulus writes the counters directly to a few ticks below the boundary and then lets them run. Two races are also provoked on purpose. One is a control write landing on the same edge as a one-shot expiry. The other is a counter write landing on a wrap edge. A behavioural model follows every clock, so the interrupt pins are compared continuously across these races.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic [1:0] {
    EN_OFF  = 2'd0,
    EN_ONCE = 2'd1,
    EN_CONT = 2'd2,
    EN_RSVD = 2'd3
  } en_mode_e;

  typedef enum logic [1:0] {
    TM_GP64    = 2'd0,
    TM_DUAL32  = 2'd1,
    TM_WDOG64  = 2'd2,
    TM_CHAIN32 = 2'd3
  } tmr_mode_e;

  localparam int OFS_ID     = 'h00;
  localparam int OFS_CNT_LO = 'h10;
  localparam int OFS_CNT_HI = 'h14;
  localparam int OFS_PER_LO = 'h18;
  localparam int OFS_PER_HI = 'h1C;
  localparam int OFS_CTRL   = 'h20;
  localparam int OFS_GCTL   = 'h24;

  localparam int EN_LO_LSB  = 6;
  localparam int EN_HI_LSB  = 22;
  localparam int GC_MODE_LSB = 2;
endpackage

// File: rtl/tp_regs.sv
module tp_regs
  import tp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        oneshot_clr,
  output logic [DATA_W-1:0] per_lo,
  output logic [DATA_W-1:0] per_hi,
  output en_mode_e          en_lo,
  output en_mode_e          en_hi,
  output logic [1:0]        rel,
  output tmr_mode_e         gmode,
  output logic [1:0]        wr_cnt
);
  logic wr_per_lo, wr_per_hi, wr_ctrl, wr_gctl;

  always_comb begin
    wr_cnt[0] = we && (addr == ADDR_W'(OFS_CNT_LO));
    wr_cnt[1] = we && (addr == ADDR_W'(OFS_CNT_HI));
    wr_per_lo = we && (addr == ADDR_W'(OFS_PER_LO));
    wr_per_hi = we && (addr == ADDR_W'(OFS_PER_HI));
    wr_ctrl   = we && (addr == ADDR_W'(OFS_CTRL));
    wr_gctl   = we && (addr == ADDR_W'(OFS_GCTL));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_lo <= '0;
      per_hi <= '0;
      en_lo  <= EN_OFF;
      en_hi  <= EN_OFF;
      rel    <= '0;
      gmode  <= TM_GP64;
    end else begin
      if (wr_per_lo) per_lo <= wdata;
      if (wr_per_hi) per_hi <= wdata;
      // a control write wins over a one-shot expiry on the same edge
      if (wr_ctrl) begin
        en_lo <= en_mode_e'(wdata[EN_LO_LSB +: 2]);
        en_hi <= en_mode_e'(wdata[EN_HI_LSB +: 2]);
      end else begin
        if (oneshot_clr[0]) en_lo <= EN_OFF;
        if (oneshot_clr[1]) en_hi <= EN_OFF;
      end
      if (wr_gctl) begin
        rel   <= wdata[1:0];
        gmode <= tmr_mode_e'(wdata[GC_MODE_LSB +: 2]);
      end
    end
  end
endmodule

// File: rtl/tp_cnt_half.sv
module tp_cnt_half #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap,
  input  logic              inc,
  output logic [DATA_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || hold) cnt <= '0;
    else if (wr)        cnt <= wdata;
    else if (wrap)      cnt <= '0;
    else if (inc)       cnt <= cnt + DATA_W'(1);
  end
endmodule

// File: rtl/timer_pair.sv
module timer_pair
  import tp_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 8,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h7A1E_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam int NHALF = 2;

  logic [DATA_W-1:0] per_lo, per_hi, cnt_lo, cnt_hi;
  logic [DATA_W-1:0] cnt [NHALF];
  en_mode_e          en_lo, en_hi;
  logic [1:0]        rel;
  tmr_mode_e         gmode;
  logic [1:0]        wr_cnt;
  logic [1:0]        oneshot_clr;
  logic [NHALF-1:0]  hold, wrap, inc;
  logic              mode64, dual, both_rel;
  logic              match_lo, match_hi, match64;
  logic              run64, run_lo, run_hi;

  tp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .oneshot_clr(oneshot_clr), .per_lo(per_lo), .per_hi(per_hi),
    .en_lo(en_lo), .en_hi(en_hi), .rel(rel), .gmode(gmode), .wr_cnt(wr_cnt)
  );

  assign cnt_lo = cnt[0];
  assign cnt_hi = cnt[1];

  always_comb begin
    mode64   = (gmode == TM_GP64);
    dual     = (gmode == TM_DUAL32);
    both_rel = rel[0] & rel[1];
    match_lo = (cnt_lo == per_lo);
    match_hi = (cnt_hi == per_hi);
    match64  = match_lo & match_hi;
    run64    = mode64 && both_rel && (en_lo != EN_OFF);
    run_lo   = dual && rel[0] && (en_lo != EN_OFF);
    run_hi   = dual && rel[1] && (en_hi != EN_OFF);

    hold[0]  = mode64 ? !both_rel : !rel[0];
    hold[1]  = mode64 ? !both_rel : !rel[1];
    wrap[0]  = run64 ? match64 : (run_lo && match_lo);
    wrap[1]  = run64 ? match64 : (run_hi && match_hi);
    inc[0]   = run64 ? !match64 : run_lo;
    inc[1]   = run64 ? (!match64 && (cnt_lo == ALL_ONES)) : run_hi;

    oneshot_clr[0] = wrap[0] && (en_lo == EN_ONCE);
    oneshot_clr[1] = run_hi && match_hi && (en_hi == EN_ONCE);
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    tp_cnt_half #(.DATA_W(DATA_W)) u_half (
      .clk(clk), .rst_n(rst_n), .hold(hold[h]), .wr(wr_cnt[h]),
      .wdata(bus_wdata), .wrap(wrap[h]), .inc(inc[h]), .cnt(cnt[h])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= wrap[0] && !wr_cnt[0];
      irq_hi <= run_hi && match_hi && !wr_cnt[1];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_ID):     bus_rdata = ID_VALUE;
      ADDR_W'(OFS_CNT_LO): bus_rdata = cnt_lo;
      ADDR_W'(OFS_CNT_HI): bus_rdata = cnt_hi;
      ADDR_W'(OFS_PER_LO): bus_rdata = per_lo;
      ADDR_W'(OFS_PER_HI): bus_rdata = per_hi;
      ADDR_W'(OFS_CTRL): begin
        bus_rdata[EN_LO_LSB +: 2] = en_lo;
        bus_rdata[EN_HI_LSB +: 2] = en_hi;
      end
      ADDR_W'(OFS_GCTL): begin
        bus_rdata[1:0]               = rel;
        bus_rdata[GC_MODE_LSB +: 2]  = gmode;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tp_checker.sv
module tp_checker
  import tp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input tmr_mode_e         gmode,
  input logic [1:0]        rel,
  input en_mode_e          en_lo,
  input logic [DATA_W-1:0] cnt_lo,
  input logic [DATA_W-1:0] cnt_hi,
  input logic              irq_lo,
  input logic              irq_hi
);
  logic ctrl_wr, cnt_lo_wr;
  assign ctrl_wr   = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign cnt_lo_wr = bus_we && (bus_addr == ADDR_W'(OFS_CNT_LO));

  // R5: an interrupt is only seen alongside a counter that has just wrapped
  p_irq_lo_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (cnt_lo == '0));
  p_irq_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (cnt_hi == '0));

  // R4: a held low half reads zero on the following clock
  p_hold_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rel[0] |=> (cnt_lo == '0));

  // R6: a one-shot expiry leaves the low enable field disabled
  p_oneshot_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && ($past(en_lo) == EN_ONCE) && !$past(ctrl_wr)) |-> (en_lo == EN_OFF));

  // R7: a disabled, released low half keeps its value
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_lo == EN_OFF) && (rel == 2'b11) && !cnt_lo_wr) |=> $stable(cnt_lo));

  // R10: the high interrupt stays quiet in 64-bit mode
  p_hi_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((gmode == TM_GP64) && $past(gmode == TM_GP64)) |-> !irq_hi);
endmodule

bind timer_pair tp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_tp_checker (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .gmode(gmode), .rel(rel), .en_lo(en_lo), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/test_timer_pair.sv
module test_timer_pair;
  localparam logic [31:0] ID_EXP = 32'h7A1E_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  timer_pair i_timer_pair (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // behavioural reference model
  logic [31:0] m_cnt [2];
  logic [31:0] m_per [2];
  logic [1:0]  m_en  [2];
  logic [3:0]  m_g;
  logic        m_irq [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_per[i] = 0; m_en[i] = 0; m_irq[i] = 0;
      end
      m_g = 0;
    end else begin
      logic [31:0] n0, n1;
      logic [63:0] full;
      logic ir0, ir1, c0, c1, h0, h1, r0, r1;
      logic [1:0] md;
      n0 = m_cnt[0]; n1 = m_cnt[1];
      ir0 = 0; ir1 = 0; c0 = 0; c1 = 0;
      r0 = m_g[0]; r1 = m_g[1]; md = m_g[3:2];
      h0 = (md == 0) ? !(r0 && r1) : !r0;
      h1 = (md == 0) ? !(r0 && r1) : !r1;
      if (md == 0) begin
        full = {m_cnt[1], m_cnt[0]};
        if (r0 && r1 && m_en[0] != 0) begin
          if (full == {m_per[1], m_per[0]}) begin
            full = 0; ir0 = 1; c0 = (m_en[0] == 1);
          end else full = full + 1;
        end
        n1 = full[63:32]; n0 = full[31:0];
      end else if (md == 1) begin
        if (r0 && m_en[0] != 0) begin
          if (m_cnt[0] == m_per[0]) begin n0 = 0; ir0 = 1; c0 = (m_en[0] == 1); end
          else n0 = m_cnt[0] + 1;
        end
        if (r1 && m_en[1] != 0) begin
          if (m_cnt[1] == m_per[1]) begin n1 = 0; ir1 = 1; c1 = (m_en[1] == 1); end
          else n1 = m_cnt[1] + 1;
        end
      end
      if (h0) n0 = 0;
      else if (bus_we && bus_addr == 8'h10) begin n0 = bus_wdata; ir0 = 0; end
      if (h1) n1 = 0;
      else if (bus_we && bus_addr == 8'h14) begin n1 = bus_wdata; ir1 = 0; end
      if (c0) m_en[0] = 0;
      if (c1) m_en[1] = 0;
      if (bus_we) begin
        case (bus_addr)
          8'h18: m_per[0] = bus_wdata;
          8'h1C: m_per[1] = bus_wdata;
          8'h20: begin m_en[0] = bus_wdata[7:6]; m_en[1] = bus_wdata[23:22]; end
          8'h24: m_g = bus_wdata[3:0];
          default: ;
        endcase
      end
      m_cnt[0] = n0; m_cnt[1] = n1; m_irq[0] = ir0; m_irq[1] = ir1;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return ID_EXP;
      8'h10: return m_cnt[0];
      8'h14: return m_cnt[1];
      8'h18: return m_per[0];
      8'h1C: return m_per[1];
      8'h20: return {8'h0, m_en[1], 14'h0, m_en[0], 6'h0};
      8'h24: return {28'h0, m_g};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // R5 R6 R10 R11: interrupt pins against the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5/R10 irq_lo", {31'h0, irq_lo}, {31'h0, m_irq[0]});
      check("R5/R6 irq_hi", {31'h0, irq_hi}, {31'h0, m_irq[1]});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1;
    check(tag, bus_rdata, m_read(a));
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] frozen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    rd_exp(8'h10, 0, "R2 cnt_lo");
    rd_exp(8'h14, 0, "R2 cnt_hi");
    rd_exp(8'h20, 0, "R2 ctrl");
    rd_exp(8'h24, 0, "R2 gctl");
    check("R2 irq", {30'h0, irq_hi, irq_lo}, 0);

    // R1 and R3: id constant, unmapped offsets
    wr(8'h00, 32'hDEAD_BEEF);
    rd_exp(8'h00, ID_EXP, "R1 id");
    wr(8'h28, 32'hFFFF_FFFF);
    rd_exp(8'h28, 0, "R3 unmapped");
    wr(8'h1C, 32'h1234_5678);
    rd_exp(8'h1C, 32'h1234_5678, "R3 per_hi");

    // R8 R9: field masking
    wr(8'h20, 32'hFFFF_FFFF);
    rd_exp(8'h20, 32'h00C0_00C0, "R8 ctrl mask");
    wr(8'h20, 0);
    wr(8'h24, 32'hFFFF_FFF4);
    rd_exp(8'h24, 32'h0000_0004, "R9 gctl mask");

    // R3 R5: dual mode, low continuous period 4
    wr(8'h24, 32'h7);
    wr(8'h18, 4);
    wr(8'h10, 0);
    wr(8'h20, 32'h0000_0080);
    idle(3);
    rd(8'h10, "R3 count");
    idle(14);
    rd(8'h10, "R5 wrap");

    // R5: counter write on a wrap edge, then carry on
    wr(8'h10, 4);
    rd(8'h10, "R5 write priority");
    idle(6);

    // R6: one-shot high half, period 3
    wr(8'h1C, 3);
    wr(8'h14, 0);
    wr(8'h20, 32'h0040_0080);
    idle(10);
    rd_exp(8'h20, 32'h0000_0080, "R6 field cleared");
    rd_exp(8'h14, 0, "R6 counter zero");

    // R6: control rewrite racing a one-shot expiry
    wr(8'h14, 1);
    wr(8'h20, 32'h0040_0080);
    wr(8'h20, 32'h0040_0080);
    rd(8'h20, "R6 race");
    idle(6);

    // R7: freeze
    wr(8'h18, 100);
    idle(5);
    wr(8'h20, 0);
    rd(8'h10, "R7 frozen a");
    @(negedge clk); bus_addr = 8'h10; #1; frozen = bus_rdata;
    idle(5);
    rd_exp(8'h10, frozen, "R7 frozen b");

    // R8: code 3 runs
    wr(8'h20, 32'h0000_00C0);
    idle(4);
    rd(8'h10, "R8 code3");

    // R4: hold low half
    wr(8'h24, 32'h6);
    rd_exp(8'h10, 0, "R4 held");
    wr(8'h10, 9);
    rd_exp(8'h10, 0, "R4 write ignored");
    rd(8'h14, "R4 high unaffected");

    // R11: free run at all ones
    wr(8'h24, 32'h7);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFC);
    wr(8'h20, 32'h0000_0080);
    idle(4);
    rd(8'h10, "R11 wrapped");

    // R9: mode 2 halts
    wr(8'h24, 32'hB);
    rd(8'h10, "R9 halt a");
    idle(4);
    rd(8'h10, "R9 halt b");

    // R10: 64-bit carry and full match
    wr(8'h24, 32'h3);
    wr(8'h20, 0);
    wr(8'h18, 2);
    wr(8'h1C, 1);
    wr(8'h14, 0);
    wr(8'h10, 32'hFFFF_FFFD);
    wr(8'h20, 32'h0000_0080);
    idle(2);
    rd(8'h14, "R10 carry");
    idle(5);
    rd(8'h10, "R10 lo after match");
    rd(8'h14, "R10 hi after match");

    // R4: one hold bit clears both in 64-bit mode
    wr(8'h24, 32'h1);
    rd_exp(8'h14, 0, "R4 64 hold hi");
    rd_exp(8'h10, 0, "R4 64 hold lo");

    idle(3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule